// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and date: seconds, minutes, hours, day of week (1 = Sunday … 7 = Saturday), date, month and a two-digit year. A reference tick from an upstream prescaler is counted down to one advance per second. A small byte-wide register bus reads and writes the fields and one control byte. The control byte selects the encoding (BCD or binary), the hour format (12 or 24 hour) and automatic daylight-saving jumps. It also has a hold bit that freezes the chain so software can load a new time.

Before each advance an update-in-progress window opens. The flag shows on a status byte and on a pin, so software can avoid reading half-changed fields. When the window closes with new values, an update-ended pulse fires if it is enabled.

The sequencer has four states. RUN counts ticks. UIP is the window before the advance. STEP is the single cycle in which the new time is loaded. HOLD is the frozen state. The transitions are:
- RUN→UIP when the count reaches the window start.
- UIP→STEP on the last tick of the second.
- STEP→RUN after one cycle.
- Any state→HOLD when the hold bit is written to 1.
- HOLD→RUN when the hold bit is written to 0.

Top module: `rtc_time_core`

## Requirements
- R1: After reset, seconds, minutes and hours read 0x00. Day of week, date and month read 0x01. Year reads 0x00. Control (address 0xB) reads 0x04 and status (address 0xA) reads 0x00. `uip` and `upd_pulse` are low.
- R2: Field addresses are 0 seconds, 2 minutes, 4 hours, 6 day of week, 7 date, 8 month, 9 year. Each advance adds one second and carries into minutes, hours, date and month, and the year goes 99→00. Day of week goes 7→1 when the hour passes 23→0.
- R3: Months 4, 6, 9 and 11 have 30 days and months 1, 3, 5, 7, 8, 10 and 12 have 31. February has 29 days when the year is divisible by 4 (including 00) and 28 days otherwise.
- R4: Control bit 1 set to 0 gives BCD bytes (decimal 23 as 0x23) and set to 1 gives binary bytes. Values are held independently of the encoding, so switching the mode re-encodes the fields on readback.
- R5: Control bit 2 set to 1 gives a 24-hour hour byte. Set to 0 it gives 12-hour format: bit 7 is PM and the low bits run 12, 1, …, 11.
- R6: With control bit 3 set, a Sunday in April dated 24 or later goes from 01:59:59 to 03:00:00. A Sunday in October dated 25 or later goes from 01:59:59 to 01:00:00 once only; the next 01:59:59 goes on to 02:00:00.
- R7: While control bit 0 (hold) is 1, no advance happens. Time writes are accepted only while hold is 1 and are ignored otherwise.
- R8: Writing control with bit 0 set forces the update-ended enable (bit 4) to 0 whatever bit 4 of the written data is. Clearing hold does not set it again.
- R9: `uip` is high from UIP_LEAD reference ticks before the advance through the STEP cycle. It falls in the first cycle the new values are visible. Status bit 7 mirrors it and status is read-only.
- R10: `upd_pulse` is high for exactly one cycle, the first cycle with `uip` low after an advance, and only when bit 4 is 1.
- R11: A hold write that lands in the STEP cycle abandons that advance. The fields keep their old values and no update-ended pulse fires.
- R12: When hold is cleared the prescaler restarts. With a tick every cycle, `uip` rises after TICKS_PER_SEC−UIP_LEAD ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference tick from prescaler, TICKS_PER_SEC per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| uip | output | 1 | Update in progress |
| upd_pulse | output | 1 | Update-ended pulse, gated by enable bit |

## Verification
The two functions that can meet in one cycle are the once-per-second STEP load and a host write of the hold bit. The bench lets `uip` rise, then waits exactly UIP_LEAD cycles so that its hold write is sampled at the end of STEP. It then judges that the seconds byte still holds its earlier value, that `uip` is low and that no update-ended pulse appears. The rollover, month, encoding and daylight-saving cases are judged by reading the bytes back in the first cycle after `uip` falls.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    typedef enum logic [1:0] {ST_RUN, ST_UIP, ST_STEP, ST_HOLD} seq_state_t;

    localparam logic [3:0] A_SEC  = 4'd0;
    localparam logic [3:0] A_MIN  = 4'd2;
    localparam logic [3:0] A_HOUR = 4'd4;
    localparam logic [3:0] A_DOW  = 4'd6;
    localparam logic [3:0] A_DATE = 4'd7;
    localparam logic [3:0] A_MON  = 4'd8;
    localparam logic [3:0] A_YEAR = 4'd9;
    localparam logic [3:0] A_STAT = 4'd10;
    localparam logic [3:0] A_CTRL = 4'd11;

    function automatic logic [7:0] to_bcd(input logic [7:0] v);
        logic [7:0] t;
        t = v % 8'd100;
        return {4'(t / 8'd10), 4'(t % 8'd10)};
    endfunction

    function automatic logic [7:0] from_bcd(input logic [7:0] b);
        return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
    endfunction

    function automatic logic [7:0] enc_val(input logic bin, input logic [7:0] v);
        return bin ? v : to_bcd(v);
    endfunction

    function automatic logic [7:0] dec_val(input logic bin, input logic [7:0] b);
        return bin ? b : from_bcd(b);
    endfunction

    function automatic logic [7:0] enc_hour(input logic bin, input logic h24,
                                            input logic [7:0] h);
        logic [7:0] h12;
        logic [7:0] e;
        if (h24) return enc_val(bin, h);
        h12 = (h == 8'd0) ? 8'd12 : ((h > 8'd12) ? 8'(h - 8'd12) : h);
        e   = enc_val(bin, h12);
        return {(h >= 8'd12), e[6:0]};
    endfunction

    function automatic logic [7:0] dec_hour(input logic bin, input logic h24,
                                            input logic [7:0] b);
        logic [7:0] v;
        if (h24) return dec_val(bin, b);
        v = dec_val(bin, {1'b0, b[6:0]});
        v = (v == 8'd12) ? 8'd0 : v;
        return b[7] ? 8'(v + 8'd12) : v;
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] year);
        if (mon == 8'd2)
            return (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
        if (mon == 8'd4 || mon == 8'd6 || mon == 8'd9 || mon == 8'd11)
            return 8'd30;
        return 8'd31;
    endfunction

endpackage

// File: rtl/rtc_sec_seq.sv
`timescale 1ns/1ps
module rtc_sec_seq
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 16,
    parameter int UIP_LEAD      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic hold_q,
    input  logic hold_n,
    output logic uip,
    output logic step
);
    localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] UIP_AT   = CW'(TICKS_PER_SEC - UIP_LEAD - 1);

    seq_state_t state_q, state_n;
    logic [CW-1:0] cnt_q;
    logic uip_start, sec_tick;

    assign uip_start = ref_tick && (cnt_q == UIP_AT);
    assign sec_tick  = ref_tick && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (hold_q || hold_n) cnt_q <= '0;
        else if (ref_tick)         cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        if (hold_n) begin
            state_n = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_RUN:  if (uip_start) state_n = ST_UIP;
                ST_UIP:  if (sec_tick)  state_n = ST_STEP;
                ST_STEP: state_n = ST_RUN;
                ST_HOLD: state_n = ST_RUN;
            endcase
        end
    end

    always_comb begin
        uip  = (state_q == ST_UIP) || (state_q == ST_STEP);
        step = (state_q == ST_STEP);
    end
endmodule

// File: rtl/rtc_calc_next.sv
`timescale 1ns/1ps
module rtc_calc_next
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      dst_en,
    input  logic      fall_done,
    output rtc_time_t nxt,
    output logic      fall_set,
    output logic      fall_clr
);
    logic at_0159;

    always_comb begin
        nxt      = cur;
        fall_set = 1'b0;
        fall_clr = (cur.hour != 8'd1);
        if (cur.sec >= 8'd59) begin
            nxt.sec = 8'd0;
            if (cur.min >= 8'd59) begin
                nxt.min = 8'd0;
                if (cur.hour >= 8'd23) begin
                    nxt.hour = 8'd0;
                    nxt.dow  = (cur.dow >= 8'd7) ? 8'd1 : cur.dow + 8'd1;
                    if (cur.date >= month_len(cur.mon, cur.year)) begin
                        nxt.date = 8'd1;
                        if (cur.mon >= 8'd12) begin
                            nxt.mon  = 8'd1;
                            nxt.year = (cur.year >= 8'd99) ? 8'd0 : cur.year + 8'd1;
                        end else begin
                            nxt.mon = cur.mon + 8'd1;
                        end
                    end else begin
                        nxt.date = cur.date + 8'd1;
                    end
                end else begin
                    nxt.hour = cur.hour + 8'd1;
                end
            end else begin
                nxt.min = cur.min + 8'd1;
            end
        end else begin
            nxt.sec = cur.sec + 8'd1;
        end

        at_0159 = dst_en && (cur.dow == 8'd1) && (cur.hour == 8'd1) &&
                  (cur.min == 8'd59) && (cur.sec == 8'd59);
        if (at_0159 && cur.mon == 8'd4 && cur.date >= 8'd24)
            nxt.hour = 8'd3;
        if (at_0159 && cur.mon == 8'd10 && cur.date >= 8'd25 && !fall_done) begin
            nxt.hour = 8'd1;
            fall_set = 1'b1;
        end
    end
endmodule

// File: rtl/rtc_time_core.sv
`timescale 1ns/1ps
module rtc_time_core
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 16,
    parameter int UIP_LEAD      = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       uip,
    output logic       upd_pulse
);
    rtc_time_t time_q, time_nxt;
    logic hold_q, bin_q, h24_q, dst_q, uie_q, fall_q, ended_q;
    logic wr_ctrl, hold_n, step, do_step, fall_set, fall_clr;
    logic [7:0] wval;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign hold_n  = wr_ctrl ? wdata[0] : hold_q;
    assign do_step = step && !(wr_ctrl && wdata[0]);
    assign wval    = dec_val(bin_q, wdata);

    rtc_sec_seq #(.TICKS_PER_SEC(TICKS_PER_SEC), .UIP_LEAD(UIP_LEAD)) u_seq (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .hold_q(hold_q), .hold_n(hold_n), .uip(uip), .step(step)
    );

    rtc_calc_next u_next (
        .cur(time_q), .dst_en(dst_q), .fall_done(fall_q),
        .nxt(time_nxt), .fall_set(fall_set), .fall_clr(fall_clr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '{year: 8'd0, mon: 8'd1, date: 8'd1, dow: 8'd1,
                        hour: 8'd0, min: 8'd0, sec: 8'd0};
        end else if (hold_q && wr_en) begin
            case (addr)
                A_SEC:  time_q.sec  <= wval;
                A_MIN:  time_q.min  <= wval;
                A_HOUR: time_q.hour <= dec_hour(bin_q, h24_q, wdata);
                A_DOW:  time_q.dow  <= wval;
                A_DATE: time_q.date <= wval;
                A_MON:  time_q.mon  <= wval;
                A_YEAR: time_q.year <= wval;
                default: ;
            endcase
        end else if (do_step) begin
            time_q <= time_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0; bin_q <= 1'b0; h24_q <= 1'b1; dst_q <= 1'b0; uie_q <= 1'b0;
        end else if (wr_ctrl) begin
            hold_q <= wdata[0];
            bin_q  <= wdata[1];
            h24_q  <= wdata[2];
            dst_q  <= wdata[3];
            uie_q  <= wdata[4] & ~wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_q  <= 1'b0;
            ended_q <= 1'b0;
        end else begin
            ended_q <= do_step;
            if (do_step) begin
                if (fall_set)      fall_q <= 1'b1;
                else if (fall_clr) fall_q <= 1'b0;
            end
        end
    end

    assign upd_pulse = ended_q & uie_q;

    always_comb begin
        case (addr)
            A_SEC:   rdata = enc_val(bin_q, time_q.sec);
            A_MIN:   rdata = enc_val(bin_q, time_q.min);
            A_HOUR:  rdata = enc_hour(bin_q, h24_q, time_q.hour);
            A_DOW:   rdata = enc_val(bin_q, time_q.dow);
            A_DATE:  rdata = enc_val(bin_q, time_q.date);
            A_MON:   rdata = enc_val(bin_q, time_q.mon);
            A_YEAR:  rdata = enc_val(bin_q, time_q.year);
            A_STAT:  rdata = {uip, 7'd0};
            A_CTRL:  rdata = {3'd0, uie_q, dst_q, h24_q, bin_q, hold_q};
            default: rdata = 8'd0;
        endcase
    end
endmodule

// File: rtl/rtc_time_core_chk.sv
`timescale 1ns/1ps
module rtc_time_core_chk
    import rtc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [3:0] addr,
    input logic       wd_b0,
    input logic       uip,
    input logic       upd_pulse,
    input rtc_time_t  time_q,
    input logic       hold_q,
    input logic       uie_q
);
    logic set_wr;
    assign set_wr = wr_en && (addr == A_CTRL) && wd_b0;

    // R7: frozen chain does not move without a host write
    p_hold_freezes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !wr_en) |=> $stable(time_q));

    // R7: no update window while frozen
    p_hold_no_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> !uip);

    // R9: outside the window only a frozen-state write can change the fields
    p_time_moves_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!uip && !(wr_en && hold_q)) |=> $stable(time_q));

    // R8: setting hold clears the update-ended enable
    p_set_clears_ie_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> !uie_q);

    // R10: pulse follows the close of the window
    p_pulse_after_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> (!uip && $past(uip)));

    // R11: a hold write abandons any pending advance
    p_abort_update_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> (!uip && !upd_pulse));
endmodule

bind rtc_time_core rtc_time_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wd_b0(wdata[0]),
    .uip(uip), .upd_pulse(upd_pulse), .time_q(time_q),
    .hold_q(hold_q), .uie_q(uie_q)
);

// File: tb/rtc_time_core_bench.sv
`timescale 1ns/1ps
module rtc_time_core_bench;
    localparam int TPS  = 16;
    localparam int LEAD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       uip, upd_pulse;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    rtc_time_core #(.TICKS_PER_SEC(TPS), .UIP_LEAD(LEAD)) u_rtc_time_core (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .uip(uip), .upd_pulse(upd_pulse)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, got cycle %0d expected < 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    // all tasks are entered and left just after a falling edge
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic rdchk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                            input logic [7:0] dw, input logic [7:0] dt,
                            input logic [7:0] mo, input logic [7:0] yr);
        wr(4'd4, h); wr(4'd2, m); wr(4'd0, s);
        wr(4'd6, dw); wr(4'd7, dt); wr(4'd8, mo); wr(4'd9, yr);
    endtask

    task automatic step_once(input logic [7:0] run_ctrl);
        wr(4'hB, run_ctrl);
        while (!uip) @(negedge clk);
        while (uip)  @(negedge clk);
    endtask

    task automatic t_reset;
        rdchk("R1 sec", 4'd0, 8'h00);   rdchk("R1 min", 4'd2, 8'h00);
        rdchk("R1 hour", 4'd4, 8'h00);  rdchk("R1 dow", 4'd6, 8'h01);
        rdchk("R1 date", 4'd7, 8'h01);  rdchk("R1 mon", 4'd8, 8'h01);
        rdchk("R1 year", 4'd9, 8'h00);  rdchk("R1 ctrl", 4'hB, 8'h04);
        rdchk("R1 status", 4'hA, 8'h00);
        chk("R1 uip", {7'd0, uip}, 8'h00);
        chk("R1 upd_pulse", {7'd0, upd_pulse}, 8'h00);
    endtask

    task automatic t_rollover;
        int k, h;
        wr(4'hB, 8'h05);
        set_time(8'h23, 8'h59, 8'h59, 8'h07, 8'h31, 8'h12, 8'h99);
        wr(4'hB, 8'h14);
        k = 0;
        while (!uip) begin @(negedge clk); k++; end
        chk("R12 ticks to window", 8'(k), 8'(TPS - LEAD));
        rdchk("R9 status in window", 4'hA, 8'h80);
        h = 0;
        while (uip) begin @(negedge clk); h++; end
        chk("R9 window length", 8'(h), 8'(LEAD + 1));
        chk("R10 pulse at close", {7'd0, upd_pulse}, 8'h01);
        rdchk("R2 sec wrap", 4'd0, 8'h00); rdchk("R2 min wrap", 4'd2, 8'h00);
        rdchk("R2 hour wrap", 4'd4, 8'h00); rdchk("R2 dow 7 to 1", 4'd6, 8'h01);
        rdchk("R2 date wrap", 4'd7, 8'h01); rdchk("R2 month wrap", 4'd8, 8'h01);
        rdchk("R2 year 99 to 00", 4'd9, 8'h00);
        @(negedge clk);
        chk("R10 pulse one cycle", {7'd0, upd_pulse}, 8'h00);
    endtask

    task automatic month_case(input string tag, input logic [7:0] dt, input logic [7:0] mo,
                              input logic [7:0] yr, input logic [7:0] edt, input logic [7:0] emo);
        wr(4'hB, 8'h05);
        set_time(8'h23, 8'h59, 8'h59, 8'h03, dt, mo, yr);
        step_once(8'h04);
        rdchk({tag, " date"}, 4'd7, edt);
        rdchk({tag, " month"}, 4'd8, emo);
    endtask

    task automatic t_months;
        month_case("R3 april 30", 8'h30, 8'h04, 8'h21, 8'h01, 8'h05);
        month_case("R3 feb non-leap", 8'h28, 8'h02, 8'h01, 8'h01, 8'h03);
        month_case("R3 feb leap 04", 8'h28, 8'h02, 8'h04, 8'h29, 8'h02);
        month_case("R3 feb 29 end", 8'h29, 8'h02, 8'h04, 8'h01, 8'h03);
        month_case("R3 feb leap 00", 8'h28, 8'h02, 8'h00, 8'h29, 8'h02);
        month_case("R3 jan 30", 8'h30, 8'h01, 8'h21, 8'h31, 8'h01);
    endtask

    task automatic t_binary;
        wr(4'hB, 8'h05);
        wr(4'd4, 8'h23);
        wr(4'hB, 8'h07);
        rdchk("R4 re-encode hour", 4'd4, 8'h17);
        wr(4'd0, 8'h3B); wr(4'd2, 8'h0A);
        step_once(8'h06);
        rdchk("R4 binary sec", 4'd0, 8'h00);
        rdchk("R4 binary min", 4'd2, 8'h0B);
        wr(4'hB, 8'h05);
        rdchk("R4 back to bcd", 4'd2, 8'h11);
    endtask

    task automatic t_12h;
        wr(4'hB, 8'h01);
        set_time(8'h91, 8'h59, 8'h59, 8'h02, 8'h10, 8'h03, 8'h10);
        step_once(8'h00);
        rdchk("R5 11PM to 12AM", 4'd4, 8'h12);
        wr(4'hB, 8'h01);
        wr(4'd4, 8'h11); wr(4'd2, 8'h59); wr(4'd0, 8'h59);
        step_once(8'h00);
        rdchk("R5 11AM to 12PM", 4'd4, 8'h92);
        wr(4'hB, 8'h05);
        rdchk("R5 noon in 24h", 4'd4, 8'h12);
    endtask

    task automatic t_dst;
        wr(4'hB, 8'h0D);
        set_time(8'h01, 8'h59, 8'h59, 8'h01, 8'h28, 8'h04, 8'h22);
        step_once(8'h0C);
        rdchk("R6 spring hour", 4'd4, 8'h03);
        rdchk("R6 spring min", 4'd2, 8'h00);
        wr(4'hB, 8'h05);
        set_time(8'h01, 8'h59, 8'h59, 8'h01, 8'h28, 8'h04, 8'h22);
        step_once(8'h04);
        rdchk("R6 disabled no jump", 4'd4, 8'h02);
        wr(4'hB, 8'h0D);
        set_time(8'h01, 8'h59, 8'h59, 8'h01, 8'h29, 8'h10, 8'h22);
        step_once(8'h0C);
        rdchk("R6 fall hour", 4'd4, 8'h01);
        rdchk("R6 fall min", 4'd2, 8'h00);
        wr(4'hB, 8'h0D);
        wr(4'd2, 8'h59); wr(4'd0, 8'h59);
        step_once(8'h0C);
        rdchk("R6 fall only once", 4'd4, 8'h02);
    endtask

    task automatic t_freeze;
        wr(4'hB, 8'h05);
        wr(4'd0, 8'h20);
        step_once(8'h04);
        rdchk("R7 advance", 4'd0, 8'h21);
        wr(4'd0, 8'h30);
        rdchk("R7 write ignored while running", 4'd0, 8'h21);
        wr(4'hB, 8'h05);
        repeat (3 * TPS) @(negedge clk);
        rdchk("R7 hold keeps sec", 4'd0, 8'h21);
        chk("R7 no window in hold", {7'd0, uip}, 8'h00);
    endtask

    task automatic t_ie;
        wr(4'hB, 8'h14);
        rdchk("R8 enable set", 4'hB, 8'h14);
        wr(4'hB, 8'h15);
        rdchk("R8 hold clears enable", 4'hB, 8'h05);
        wr(4'hB, 8'h04);
        rdchk("R8 release keeps clear", 4'hB, 8'h04);
        wr(4'hA, 8'hFF);
        rdchk("R9 status read-only", 4'hA, {uip, 7'd0});
        wr(4'hB, 8'h05);
        wr(4'd0, 8'h40);
        step_once(8'h04);
        chk("R10 no pulse when disabled", {7'd0, upd_pulse}, 8'h00);
        rdchk("R10 advance without pulse", 4'd0, 8'h41);
    endtask

    task automatic t_collision;
        wr(4'hB, 8'h05);
        wr(4'd0, 8'h10);
        wr(4'hB, 8'h14);
        while (!uip) @(negedge clk);
        repeat (LEAD) @(negedge clk);
        chk("R11 in advance cycle", {7'd0, uip}, 8'h01);
        wr(4'hB, 8'h15);
        chk("R11 window dropped", {7'd0, uip}, 8'h00);
        chk("R11 no pulse", {7'd0, upd_pulse}, 8'h00);
        rdchk("R11 advance abandoned", 4'd0, 8'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rollover();
        t_months();
        t_binary();
        t_12h();
        t_dst();
        t_freeze();
        t_ie();
        t_collision();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule